// File: doc/BRIEF.md
# Multi-Channel ADC Sequencer Controller

This controller drives one shared successive-approximation converter through a group of up to four analog inputs in a single one-shot pass. Software programs a control word that holds a group select, a channel count, an interrupt enable and a start bit. A run begins either from that start bit or from a rising edge on an external trigger pin. The sequencer then issues one conversion request per channel. It waits for the converter's completion strobe after each request and files each result into the data register that belongs to that channel. After the last channel, the start bit drops by itself, the done flag rises, and an interrupt line goes high if it is enabled.

Software can halt a run by writing the start bit to 0. Any write that has the start bit at 1 restarts the run from the first channel of the group, and it may change the group and count in the same write. If a conversion is in flight when a run is halted or restarted, that conversion is allowed to finish at the converter, but its value is thrown away. The sequencer states are `ST_IDLE` (no conversion outstanding), `ST_LAUNCH` (one-cycle request to the converter), `ST_WAIT` (waiting for completion) and `ST_DRAIN` (waiting out a discarded conversion). The transitions are:
- IDLE→LAUNCH when the start bit is 1 and no halt is written.
- LAUNCH→WAIT normally, or LAUNCH→DRAIN on a halt or restart.
- WAIT→LAUNCH when a channel completes and more channels remain.
- WAIT→IDLE when the last channel completes, or when a completion arrives together with a halt or restart.
- WAIT→DRAIN on a halt or restart with no completion.
- DRAIN→IDLE on completion.

Top module: `adc_seq_ctrl`

## Requirements
- R1: A write to address 0 sets the control word: start in bit 0, group in bit 1, count in bits 3:2, done in bit 4, interrupt enable in bit 5. A run starts when a write sets bit 0 to 1, or on a rising edge of `ext_trig` while the start bit is 0. A trigger edge during a run has no effect on the channel order.
- R2: The first channel requested is 0 when the group bit is 0, and 4 when it is 1; `conv_ch` carries the channel number.
- R3: Each request is a single-cycle `conv_start` pulse. The next channel in the group is requested automatically after the previous completion, in ascending order.
- R4: Each completed result is stored in that channel's register, which is read at address 8 + channel on `rd_data[9:0]`.
- R5: After the last channel completes, the start bit reads 0 and the done flag reads 1.
- R6: `irq` is high exactly while the done flag and interrupt enable are both 1. Done is cleared only by a control write with bit 4 at 0.
- R7: Writing the start bit to 0 during a run stops further requests and leaves done at 0. The in-flight conversion's result register keeps its old value.
- R8: A control write with start 1 during a run restarts from the first channel of the newly written group and count. The interrupted conversion's result is discarded.
- R9: A count of 0, 1, 2 or 3 converts 1, 2, 3 or 4 channels upward from the group's first channel; group 0 with count 2 converts channels 0, 1, 2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 4 | Write address (0 = control) |
| wr_data | input | 16 | Write data |
| rd_addr | input | 4 | Read address (0 = control, 8..15 = results) |
| rd_data | output | 16 | Combinational read data |
| ext_trig | input | 1 | External start trigger, rising-edge sensitive |
| conv_start | output | 1 | One-cycle conversion request |
| conv_ch | output | 3 | Channel for the current request |
| conv_done | input | 1 | Converter completion strobe |
| conv_result | input | 10 | Converter result, valid with `conv_done` |
| irq | output | 1 | Sequence-complete interrupt request |

## Verification
Every cycle, the bound checker confirms several properties:
- A run from idle requests the group's first channel.
- Each follow-on request names the channel one above the previous one.
- Requests last one cycle.
- A start bit that falls without a write leaves done set.
- A start bit cleared by software is never followed by a request in the same cycle.
- The interrupt follows a rising done flag when it is enabled.

Only the scenarios can show some behaviours. These are that results land in the right registers, that discarded conversions leave their registers untouched, that a combined write takes effect with its new selection, and that a trigger during a run is ignored.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;
    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_LAUNCH = 2'd1,
        ST_WAIT   = 2'd2,
        ST_DRAIN  = 2'd3
    } seq_state_t;

    localparam int unsigned BIT_START = 0;
    localparam int unsigned BIT_GROUP = 1;
    localparam int unsigned BIT_CNT   = 2;
endpackage

// File: rtl/adc_seq_ctrl_regs.sv
module adc_seq_ctrl_regs
    import adc_seq_pkg::*;
#(
    parameter int unsigned DATA_W = 16,
    parameter int unsigned ADDR_W = 4,
    parameter int unsigned IDX_W  = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              ext_trig,
    input  logic              seq_finish,
    output logic              ctrl_wr,
    output logic              kick,
    output logic              abort,
    output logic              start_bit,
    output logic              group_bit,
    output logic [IDX_W-1:0]  ch_cnt,
    output logic              done_bit,
    output logic              ie_bit
);
    localparam int unsigned BIT_DONE = BIT_CNT + IDX_W;
    localparam int unsigned BIT_IE   = BIT_DONE + 1;

    logic trig_q;
    logic trig_edge;

    assign ctrl_wr   = wr_en && (wr_addr == '0);
    assign trig_edge = ext_trig && !trig_q;
    assign kick      = (ctrl_wr && wr_data[BIT_START])
                     || (!ctrl_wr && trig_edge && !start_bit);
    assign abort     = ctrl_wr && !wr_data[BIT_START] && start_bit;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            trig_q <= 1'b0;
        end else begin
            trig_q <= ext_trig;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            start_bit <= 1'b0;
            group_bit <= 1'b0;
            ch_cnt    <= '0;
            done_bit  <= 1'b0;
            ie_bit    <= 1'b0;
        end else if (ctrl_wr) begin
            start_bit <= wr_data[BIT_START];
            group_bit <= wr_data[BIT_GROUP];
            ch_cnt    <= wr_data[BIT_CNT +: IDX_W];
            ie_bit    <= wr_data[BIT_IE];
            if (!wr_data[BIT_DONE]) begin
                done_bit <= 1'b0;
            end
        end else if (kick) begin
            start_bit <= 1'b1;
        end else if (seq_finish) begin
            start_bit <= 1'b0;
            done_bit  <= 1'b1;
        end
    end
endmodule

// File: rtl/adc_seq_fsm.sv
module adc_seq_fsm
    import adc_seq_pkg::*;
#(
    parameter int unsigned IDX_W = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_bit,
    input  logic             kick,
    input  logic             abort,
    input  logic [IDX_W-1:0] ch_cnt,
    input  logic             conv_done,
    output seq_state_t       state,
    output logic [IDX_W-1:0] idx,
    output logic             conv_start,
    output logic             store_en,
    output logic             seq_finish
);
    seq_state_t       state_d;
    logic [IDX_W-1:0] idx_d;
    logic             halt;
    logic             last_ch;

    assign halt    = kick || abort;
    assign last_ch = (idx == ch_cnt);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_IDLE;
            idx   <= '0;
        end else begin
            state <= state_d;
            idx   <= idx_d;
        end
    end

    always_comb begin
        state_d = state;
        idx_d   = idx;
        unique case (state)
            ST_IDLE: begin
                idx_d = '0;
                if (start_bit && !abort) begin
                    state_d = ST_LAUNCH;
                end
            end
            ST_LAUNCH: begin
                state_d = halt ? ST_DRAIN : ST_WAIT;
            end
            ST_WAIT: begin
                if (conv_done) begin
                    if (halt || last_ch) begin
                        state_d = ST_IDLE;
                    end else begin
                        state_d = ST_LAUNCH;
                        idx_d   = idx + 1'b1;
                    end
                end else if (halt) begin
                    state_d = ST_DRAIN;
                end
            end
            ST_DRAIN: begin
                if (conv_done) begin
                    state_d = ST_IDLE;
                end
            end
            default: state_d = ST_IDLE;
        endcase
    end

    always_comb begin
        conv_start = 1'b0;
        store_en   = 1'b0;
        seq_finish = 1'b0;
        unique case (state)
            ST_IDLE:   ;
            ST_LAUNCH: conv_start = 1'b1;
            ST_WAIT: begin
                store_en   = conv_done && !halt;
                seq_finish = conv_done && !halt && last_ch;
            end
            ST_DRAIN:  ;
            default:   ;
        endcase
    end
endmodule

// File: rtl/adc_seq_results.sv
module adc_seq_results #(
    parameter int unsigned NUM_CH = 8,
    parameter int unsigned CH_W   = 3,
    parameter int unsigned RES_W  = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             store_en,
    input  logic [CH_W-1:0]  store_ch,
    input  logic [RES_W-1:0] store_data,
    input  logic [CH_W-1:0]  rd_ch,
    output logic [RES_W-1:0] rd_val
);
    logic [RES_W-1:0] bank [NUM_CH];

    for (genvar g = 0; g < NUM_CH; g++) begin : g_slot
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                bank[g] <= '0;
            end else if (store_en && (store_ch == CH_W'(g))) begin
                bank[g] <= store_data;
            end
        end
    end

    assign rd_val = bank[rd_ch];
endmodule

// File: rtl/adc_seq_ctrl.sv
module adc_seq_ctrl
    import adc_seq_pkg::*;
#(
    parameter int unsigned GROUP_SIZE = 4,
    parameter int unsigned RES_W      = 10,
    parameter int unsigned DATA_W     = 16,
    parameter int unsigned ADDR_W     = 4
) (
    input  logic                                  clk,
    input  logic                                  rst_n,
    input  logic                                  wr_en,
    input  logic [ADDR_W-1:0]                     wr_addr,
    input  logic [DATA_W-1:0]                     wr_data,
    input  logic [ADDR_W-1:0]                     rd_addr,
    output logic [DATA_W-1:0]                     rd_data,
    input  logic                                  ext_trig,
    output logic                                  conv_start,
    output logic [$clog2(GROUP_SIZE*2)-1:0]       conv_ch,
    input  logic                                  conv_done,
    input  logic [RES_W-1:0]                      conv_result,
    output logic                                  irq
);
    localparam int unsigned IDX_W  = $clog2(GROUP_SIZE);
    localparam int unsigned NUM_CH = GROUP_SIZE * 2;
    localparam int unsigned CH_W   = $clog2(NUM_CH);
    localparam int unsigned CTRL_W = IDX_W + 4;

    logic             ctrl_wr;
    logic             kick;
    logic             abort;
    logic             start_bit;
    logic             group_bit;
    logic [IDX_W-1:0] ch_cnt;
    logic             done_bit;
    logic             ie_bit;
    seq_state_t       state;
    logic [IDX_W-1:0] idx;
    logic             store_en;
    logic             seq_finish;
    logic [RES_W-1:0] res_val;
    logic [CTRL_W-1:0] ctrl_word;

    adc_seq_ctrl_regs #(
        .DATA_W(DATA_W),
        .ADDR_W(ADDR_W),
        .IDX_W (IDX_W)
    ) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (wr_en),
        .wr_addr   (wr_addr),
        .wr_data   (wr_data),
        .ext_trig  (ext_trig),
        .seq_finish(seq_finish),
        .ctrl_wr   (ctrl_wr),
        .kick      (kick),
        .abort     (abort),
        .start_bit (start_bit),
        .group_bit (group_bit),
        .ch_cnt    (ch_cnt),
        .done_bit  (done_bit),
        .ie_bit    (ie_bit)
    );

    adc_seq_fsm #(
        .IDX_W(IDX_W)
    ) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .start_bit (start_bit),
        .kick      (kick),
        .abort     (abort),
        .ch_cnt    (ch_cnt),
        .conv_done (conv_done),
        .state     (state),
        .idx       (idx),
        .conv_start(conv_start),
        .store_en  (store_en),
        .seq_finish(seq_finish)
    );

    assign conv_ch = {group_bit, idx};

    adc_seq_results #(
        .NUM_CH(NUM_CH),
        .CH_W  (CH_W),
        .RES_W (RES_W)
    ) u_res (
        .clk       (clk),
        .rst_n     (rst_n),
        .store_en  (store_en),
        .store_ch  (conv_ch),
        .store_data(conv_result),
        .rd_ch     (rd_addr[CH_W-1:0]),
        .rd_val    (res_val)
    );

    assign ctrl_word = {ie_bit, done_bit, ch_cnt, group_bit, start_bit};
    assign irq       = done_bit && ie_bit;

    always_comb begin
        rd_data = '0;
        if (rd_addr[ADDR_W-1]) begin
            rd_data = DATA_W'(res_val);
        end else if (rd_addr == '0) begin
            rd_data = DATA_W'(ctrl_word);
        end
    end
endmodule

// File: rtl/adc_seq_checker.sv
module adc_seq_checker
    import adc_seq_pkg::*;
#(
    parameter int unsigned CH_W  = 3,
    parameter int unsigned IDX_W = 2
) (
    input logic            clk,
    input logic            rst_n,
    input logic            conv_start,
    input logic [CH_W-1:0] conv_ch,
    input logic            irq,
    input logic            start_bit,
    input logic            done_bit,
    input logic            ie_bit,
    input logic            group_bit,
    input logic            ctrl_wr,
    input seq_state_t      state
);
    p_first_channel_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (conv_start && $past(state) == ST_IDLE)
        |-> (conv_ch[IDX_W-1:0] == '0 && conv_ch[CH_W-1] == group_bit));

    p_next_channel_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (conv_start && $past(state) == ST_WAIT)
        |-> (conv_ch == CH_W'($past(conv_ch) + 1'b1)));

    p_single_pulse_r3: assert property (@(posedge clk) disable iff (!rst_n)
        conv_start |=> !conv_start);

    p_auto_clear_r5: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(start_bit) && !$past(ctrl_wr)) |-> done_bit);

    p_irq_raise_r6: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(done_bit) && ie_bit) |-> irq);

    p_irq_needs_done_r6: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> done_bit);

    p_halt_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(start_bit) && $past(ctrl_wr)) |-> !conv_start);
endmodule

bind adc_seq_ctrl adc_seq_checker #(
    .CH_W (CH_W),
    .IDX_W(IDX_W)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .conv_start(conv_start),
    .conv_ch   (conv_ch),
    .irq       (irq),
    .start_bit (start_bit),
    .done_bit  (done_bit),
    .ie_bit    (ie_bit),
    .group_bit (group_bit),
    .ctrl_wr   (ctrl_wr),
    .state     (state)
);

// File: tb/adc_seq_ctrl_bench.sv
`timescale 1ns/1ps
module adc_seq_ctrl_bench;
    localparam int LAT = 4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [3:0]  wr_addr = '0;
    logic [15:0] wr_data = '0;
    logic [3:0]  rd_addr = '0;
    logic [15:0] rd_data;
    logic        ext_trig = 1'b0;
    logic        conv_start;
    logic [2:0]  conv_ch;
    logic        conv_done = 1'b0;
    logic [9:0]  conv_result = '0;
    logic        irq;

    int checks = 0;
    int errors = 0;
    int starts_seen = 0;
    int tag = 1;
    int exp_q[$];
    logic [9:0] model_last [8];
    bit finished = 0;

    always #5 clk = ~clk;

    adc_seq_ctrl u_adc_seq_ctrl (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
        .ext_trig(ext_trig), .conv_start(conv_start), .conv_ch(conv_ch),
        .conv_done(conv_done), .conv_result(conv_result), .irq(irq)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic logic [15:0] mk(input bit st, input bit grp, input int cnt,
                                       input bit dn, input bit ie);
        return {10'b0, ie, dn, 2'(cnt), grp, st};
    endfunction

    // converter model: fixed latency responder
    initial begin
        for (int i = 0; i < 8; i++) model_last[i] = '0;
        forever begin
            @(negedge clk);
            conv_done = 1'b0;
            if (conv_start) begin
                automatic int ch = int'(conv_ch);
                repeat (LAT) @(negedge clk);
                conv_result = 10'(ch * 64 + (tag % 64));
                model_last[ch] = conv_result;
                tag++;
                conv_done = 1'b1;
            end
        end
    end

    // scoreboard monitor: channel order
    initial begin
        forever begin
            @(negedge clk);
            if (conv_start) begin
                starts_seen++;
                if (exp_q.size() == 0) begin
                    check(1'b0, "R3 unexpected request", int'(conv_ch), -1);
                end else begin
                    automatic int e = exp_q.pop_front();
                    check(int'(conv_ch) == e, "R2/R3/R9 channel order", int'(conv_ch), e);
                end
            end
        end
    end

    task automatic wr_ctrl(input logic [15:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = 4'd0; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [3:0] a, output logic [15:0] d);
        @(negedge clk);
        rd_addr = a;
        #1;
        d = rd_data;
    endtask

    task automatic wait_done();
        logic [15:0] d;
        for (int i = 0; i < 300; i++) begin
            rd(4'd0, d);
            if (d[4]) break;
        end
    endtask

    task automatic push_run(input bit grp, input int cnt);
        for (int i = 0; i <= cnt; i++) exp_q.push_back(grp * 4 + i);
    endtask

    task automatic check_results(input bit grp, input int cnt, input string req);
        logic [15:0] d;
        for (int i = 0; i <= cnt; i++) begin
            rd(4'(8 + grp * 4 + i), d);
            check(d[9:0] == model_last[grp * 4 + i], req, int'(d), int'(model_last[grp * 4 + i]));
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [15:0] d;
        logic [9:0] snap;
        int base;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // reset state
        rd(4'd0, d);
        check(d == 16'd0, "R5 reset control word", int'(d), 0);
        check(irq == 1'b0 && conv_start == 1'b0, "R6 reset irq", int'(irq), 0);

        // R1 R2 R9: software start, group 0, count 2 -> channels 0,1,2
        push_run(1'b0, 2);
        wr_ctrl(mk(1, 0, 2, 0, 1));
        wait_done();
        rd(4'd0, d);
        check(d[0] == 1'b0 && d[4] == 1'b1, "R5 start cleared done set", int'(d[5:0]), 16);
        check(irq == 1'b1, "R6 irq with enable", int'(irq), 1);
        check(exp_q.size() == 0, "R9 three channels converted", exp_q.size(), 0);
        check_results(1'b0, 2, "R4 result register group0");

        // R6: done cleared by write of 0
        wr_ctrl(mk(0, 0, 2, 0, 1));
        rd(4'd0, d);
        check(d[4] == 1'b0 && irq == 1'b0, "R6 done cleared by write", int'(irq), 0);

        // R1 trigger start, group 1, count 3, ie=0; trigger during run ignored
        wr_ctrl(mk(0, 1, 3, 0, 0));
        push_run(1'b1, 3);
        @(negedge clk); ext_trig = 1'b1;
        @(negedge clk); @(negedge clk); ext_trig = 1'b0;
        base = starts_seen;
        wait (starts_seen == base + 2);
        @(negedge clk); ext_trig = 1'b1;
        @(negedge clk); ext_trig = 1'b0;
        wait_done();
        rd(4'd0, d);
        check(d[4] == 1'b1 && d[0] == 1'b0, "R1 trigger run completes", int'(d[5:0]), 16);
        check(irq == 1'b0, "R6 no irq when disabled", int'(irq), 0);
        check(exp_q.size() == 0, "R1 trigger mid-run ignored", exp_q.size(), 0);
        check_results(1'b1, 3, "R4 result register group1");

        // R9: count 0 in group 1 -> only channel 4
        push_run(1'b1, 0);
        wr_ctrl(mk(1, 1, 0, 0, 1));
        wait_done();
        repeat (10) @(negedge clk);
        check(exp_q.size() == 0, "R9 single channel", exp_q.size(), 0);
        check_results(1'b1, 0, "R4 single channel result");

        // R7: abort during second conversion
        snap = model_last[1];
        exp_q.push_back(0); exp_q.push_back(1);
        base = starts_seen;
        wr_ctrl(mk(1, 0, 3, 0, 1));
        wait (starts_seen == base + 2);
        @(negedge clk);
        wr_ctrl(mk(0, 0, 3, 0, 1));
        repeat (30) @(negedge clk);
        rd(4'd0, d);
        check(d[0] == 1'b0 && d[4] == 1'b0, "R7 halted without done", int'(d[5:0]), 0);
        check(irq == 1'b0, "R7 no irq after halt", int'(irq), 0);
        rd(4'd9, d);
        check(d[9:0] == snap, "R7 in-flight result discarded", int'(d), int'(snap));
        rd(4'd8, d);
        check(d[9:0] == model_last[0], "R7 completed channel kept", int'(d), int'(model_last[0]));

        // R8: restart with new selection in one write
        snap = model_last[0];
        exp_q.push_back(0);
        base = starts_seen;
        wr_ctrl(mk(1, 0, 3, 0, 1));
        wait (starts_seen == base + 1);
        @(negedge clk);
        push_run(1'b1, 1);
        wr_ctrl(mk(1, 1, 1, 0, 1));
        wait_done();
        repeat (10) @(negedge clk);
        check(exp_q.size() == 0, "R8 restart order 4,5", exp_q.size(), 0);
        rd(4'd8, d);
        check(d[9:0] == snap, "R8 interrupted result discarded", int'(d), int'(snap));
        check_results(1'b1, 1, "R8 new selection results");
        check(irq == 1'b1, "R8 irq after restarted run", int'(irq), 1);

        finished = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule